// File: doc/BRIEF.md
# Interrupt Request Qualifier and Priority Encoder

This block sits in front of a processor's instruction sequencer. It takes seven active-low interrupt request lines and the 3-bit interrupt mask from the processor status word. Each line is sampled on the falling clock edge and must be seen low on two samples in a row before it counts. Lines 1 to 6 are level requests. A level request is honoured only while its number is strictly above the mask. Line 7 cannot be masked. It raises a request once for each qualified falling transition. It raises another request whenever the mask drops from 7 to a lower value while the line is still low.

The block does not act on a request as soon as it qualifies. The sequencer pulses a boundary strobe at each instruction boundary, and also when higher-priority exception processing has finished. On that strobe the block takes a fresh snapshot of the highest level that is currently valid. No level is kept from one snapshot to the next, so a higher request that appears later wins at the next strobe. An acknowledge strobe for level 7 clears the stored line-7 request, so one transition is serviced exactly once.

Top module: `irq_qualifier`

## Requirements
- R1: While reset is low, `pend` is 0 and `pend_lvl` is 3'b000. Reset clears the stored line-7 request. Reset treats every line, and the line-7 history, as released, so a line 7 held low across reset release produces one new request. Reset also treats the previous mask as not 7.
- R2: Line n (1..6) of `irq_n[7:1]` is a request when low. It is valid only while n is strictly greater than `mask`. When several lines are valid, the highest one is chosen.
- R3: A line at or below the mask is ignored and leaves no record. If the mask is later lowered after that line has been released, no request appears.
- R4: A line counts only after it is seen low on two consecutive falling-edge samples. A low pulse seen on a single sample has no effect on any output, on line 7 as well as on lines 1 to 6.
- R5: `pend` and `pend_lvl` change only on a rising edge where `boundary` is 1. At that edge they take the highest level that is valid in that cycle.
- R6: The pending level is not held between snapshots. A higher request replaces a lower one at the next boundary. A withdrawn request disappears at the next boundary.
- R7: A qualified falling transition on line 7 stores a level-7 request whatever the mask value. While the line stays low, no further request follows once that request has been acknowledged.
- R8: When the mask changes from 7 to a lower value while line 7 is qualified low, a new level-7 request is stored.
- R9: A clock edge with `ack7` at 1 clears the stored level-7 request. If a new line-7 request is raised on the same edge, the new request wins and stays stored.
- R10: `pend_lvl` carries the level in plain binary, 3'b001 to 3'b111. When no request is present it is 3'b000 and `pend` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the lines are sampled on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_n | input | 7 | Request lines 7..1, active low |
| mask | input | 3 | Current interrupt mask from the status word |
| boundary | input | 1 | Instruction-boundary / exception-done strobe |
| ack7 | input | 1 | Acknowledge of a level-7 service |
| pend | output | 1 | A request is presented |
| pend_lvl | output | 3 | Level of the presented request |

## Verification
Two functions can fall on the same clock edge. The acknowledge of a level-7 request can arrive on the same edge as a new level-7 request, which is raised when the mask drops from 7 while line 7 is still low. The bench drives `ack7` high and lowers the mask in one cycle. It expects the request to survive, so level 7 is still presented at the following boundaries, and a second acknowledge alone clears it. A behavioural reference model, stepped on both clock edges, judges every cycle.

// File: rtl/irq_qualifier.sv
module irq_qualifier #(
  parameter int LW = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [(1<<LW)-1:1]    irq_n,
  input  logic [LW-1:0]         mask,
  input  logic                  boundary,
  input  logic                  ack7,
  output logic                  pend,
  output logic [LW-1:0]         pend_lvl
);
  localparam int        TOP   = (1 << LW) - 1;
  localparam [LW-1:0]   TOP_V = LW'(TOP);

  logic [TOP:1] smp_a, smp_b;
  logic         old7;
  logic [TOP:1] live;
  logic         rise7, drop7, flag7;
  logic [LW-1:0] mask_q, best;

  // two falling-edge samples plus one extra history bit for the top line
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_a <= '1;
      smp_b <= '1;
      old7  <= 1'b1;
    end else begin
      smp_a <= irq_n;
      smp_b <= smp_a;
      old7  <= smp_b[TOP];
    end
  end

  assign live  = ~smp_a & ~smp_b;
  assign rise7 = live[TOP] & old7;
  assign drop7 = (mask_q == TOP_V) && (mask != TOP_V) && live[TOP];

  always_comb begin
    best = '0;
    for (int i = 1; i < TOP; i++)
      if (live[i] && (i > int'(mask))) best = LW'(i);
    if (flag7) best = TOP_V;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      flag7    <= 1'b0;
      pend     <= 1'b0;
      pend_lvl <= '0;
    end else begin
      mask_q <= mask;
      if (rise7 || drop7) flag7 <= 1'b1;
      else if (ack7)      flag7 <= 1'b0;
      if (boundary) begin
        pend     <= (best != '0);
        pend_lvl <= best;
      end
    end
  end
endmodule

module irq_qualifier_chk #(
  parameter int LW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [LW-1:0] mask,
  input logic [LW-1:0] mask_q,
  input logic          boundary,
  input logic          ack7,
  input logic          q7,
  input logic          rise7,
  input logic          drop7,
  input logic          flag7,
  input logic          pend,
  input logic [LW-1:0] pend_lvl
);
  localparam [LW-1:0] TOP_V = LW'((1 << LW) - 1);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> ($stable(pend) && $stable(pend_lvl)));

  p_enc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pend == (pend_lvl != '0));

  p_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (!pend || pend_lvl == TOP_V || pend_lvl > $past(mask)));

  p_remask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == TOP_V && mask != TOP_V && q7) |=> flag7);

  p_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rise7 |=> flag7);

  p_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack7 && !rise7 && !drop7) |=> !flag7);

  p_nmi_shown_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && flag7) |=> (pend && pend_lvl == TOP_V));
endmodule

bind irq_qualifier irq_qualifier_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mask(mask), .mask_q(mask_q),
  .boundary(boundary), .ack7(ack7), .q7(live[TOP]), .rise7(rise7),
  .drop7(drop7), .flag7(flag7), .pend(pend), .pend_lvl(pend_lvl)
);

// File: tb/irq_qualifier_test.sv
module irq_qualifier_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:1] irq_n = '1;
  logic [2:0] mask = 3'd0;
  logic       boundary = 1'b1;
  logic       ack7 = 1'b0;
  logic       pend;
  logic [2:0] pend_lvl;

  int    errors = 0;
  int    checks = 0;
  string req = "R1";
  bit    running = 1'b0;

  irq_qualifier uut (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .mask(mask),
    .boundary(boundary), .ack7(ack7), .pend(pend), .pend_lvl(pend_lvl)
  );

  always #10 clk = ~clk;

  // reference model: sample history (h0 newest), nmi flag, mask history
  bit h0[1:7], h1[1:7], h2[1:7];
  bit m_flag;
  int m_prev;
  bit exp_pend;
  int exp_lvl;

  always @(negedge clk or negedge rst_n) begin
    for (int i = 1; i <= 7; i++) begin
      if (!rst_n) begin h0[i] = 1; h1[i] = 1; h2[i] = 1; end
      else begin h2[i] = h1[i]; h1[i] = h0[i]; h0[i] = irq_n[i]; end
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flag = 0; m_prev = 0; exp_pend = 0; exp_lvl = 0;
    end else begin
      bit low7, rise, drop;
      int b;
      low7 = !h0[7] && !h1[7];
      rise = low7 && h2[7];
      drop = (m_prev == 7) && (mask != 7) && low7;
      b = 0;
      for (int i = 1; i <= 6; i++)
        if (!h0[i] && !h1[i] && i > mask) b = i;
      if (m_flag) b = 7;
      if (boundary) begin exp_lvl = b; exp_pend = (b != 0); end
      if (rise || drop) m_flag = 1;
      else if (ack7) m_flag = 0;
      m_prev = mask;
    end
  end

  task automatic check(input string r, input bit ap, input int al, input bit ep, input int el);
    checks++;
    if (ap !== ep || al != el) begin
      errors++;
      $display("FAIL %s: pend=%0b lvl=%0d expected pend=%0b lvl=%0d at %0t", r, ap, al, ep, el, $time);
    end
  endtask

  always @(negedge clk)
    if (running && rst_n) check(req, pend, int'(pend_lvl), exp_pend, exp_lvl);

  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #35;
    check("R1", pend, int'(pend_lvl), 1'b0, 0);
    tick(1);
    rst_n = 1'b1;
    running = 1'b1;
    tick(3);

    req = "R2"; irq_n[3] = 1'b0; tick(5);
    req = "R10"; irq_n[5] = 1'b0; tick(5);
    req = "R2"; irq_n[3] = 1'b1; irq_n[5] = 1'b1; tick(5);

    req = "R4"; irq_n[6] = 1'b0; tick(1); irq_n[6] = 1'b1; tick(5);

    req = "R3"; mask = 3'd4; irq_n[2] = 1'b0; irq_n[4] = 1'b0; tick(5);
    irq_n[2] = 1'b1; irq_n[4] = 1'b1; tick(1); mask = 3'd0; tick(5);

    req = "R5"; boundary = 1'b0; irq_n[5] = 1'b0; tick(5);
    boundary = 1'b1; tick(1); boundary = 1'b0;
    irq_n[5] = 1'b1; tick(5);
    boundary = 1'b1; tick(1); boundary = 1'b0; tick(3); boundary = 1'b1;

    req = "R6"; irq_n[2] = 1'b0; tick(4); irq_n[6] = 1'b0; tick(4);
    irq_n[6] = 1'b1; tick(4); irq_n[2] = 1'b1; tick(4);

    req = "R7"; mask = 3'd7; irq_n[2] = 1'b0; irq_n[7] = 1'b0; tick(5);
    ack7 = 1'b1; tick(1); ack7 = 1'b0; tick(6);

    req = "R8"; mask = 3'd3; tick(5);
    ack7 = 1'b1; tick(1); ack7 = 1'b0; tick(3);
    mask = 3'd7; tick(3);

    req = "R9"; mask = 3'd1; ack7 = 1'b1; tick(1); ack7 = 1'b0; tick(4);
    ack7 = 1'b1; tick(1); ack7 = 1'b0; tick(4);

    req = "R4"; irq_n[7] = 1'b1; irq_n[2] = 1'b1; tick(4);
    irq_n[7] = 1'b0; tick(1); irq_n[7] = 1'b1; tick(5);

    req = "R1"; irq_n[7] = 1'b0; tick(3);
    rst_n = 1'b0; running = 1'b0; tick(1); #6;
    check("R1", pend, int'(pend_lvl), 1'b0, 0);
    tick(1); rst_n = 1'b1; running = 1'b1; tick(6);
    irq_n = '1; tick(4);

    running = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule